// File: doc/BRIEF.md
# Superincreasing Knapsack Cipher Engine

This block does the arithmetic for a knapsack-type public-key scheme. It holds eight public weights and eight private weights, a modulus, a multiplier and the modular inverse of that multiplier. Software loads all of these through a register write port. Key generation and computing the inverse are done elsewhere. A start pulse launches one of two operations.

Encryption adds up the public weights picked by the set bits of an 8-bit block, and the result appears in a single cycle. Decryption takes a ciphertext and first maps it back to a superincreasing sum: it multiplies the ciphertext by the stored inverse modulo the modulus, using a shift-and-add loop that handles one ciphertext bit per cycle. It then walks the private weights from the highest index down, one weight per cycle, and takes each weight that still fits in the running remainder. The recovered block is reported together with a flag that is set when the walk leaves a nonzero remainder.

A combinational key check watches the stored key at all times. It reports a configuration error when the private weights are not superincreasing, when the modulus does not exceed their total, or when the multiplier or the inverse is not below the modulus.

Top module: `knap_engine`

## Requirements
- R1: After reset, done, busy, result and result_err are 0. config_error is 1, because the all-zero key is invalid.
- R2: A register write with cfg_we=1 stores cfg_wdata at cfg_addr. Address i (0..7) is public weight i, address 8+i is private weight i, 16 is the modulus, 17 is the multiplier and 18 is the inverse. Weights take the low 16 bits of the write data.
- R3: An encrypt (start=1, op_decrypt=0, engine idle) sets result to the sum of public weight i over every i where blk_in[i]=1. result_err is 0. done is high in the cycle right after the edge that samples start.
- R4: A decrypt (start=1, op_decrypt=1, engine idle) computes S = ct_in * inverse mod modulus. For k from 7 down to 0 it sets result bit k when private weight k is at most the remainder, and subtracts that weight when it does. Bits above 7 of result are 0. done rises 30 cycles after the sampling edge.
- R5: On a decrypt, result_err is 1 exactly when the remainder left after the walk is nonzero.
- R6: busy is 1 from the edge that accepts a decrypt until done. A start while busy is ignored: it produces no done and no change of result.
- R7: A register write in a cycle where busy is 1, or in the same cycle as an accepted start, is discarded.
- R8: config_error is 1 when any of these holds: a private weight is not strictly greater than the sum of all lower-indexed private weights; the modulus is not greater than the sum of all private weights; the multiplier is at least the modulus; the inverse is at least the modulus.
- R9: done is a single-cycle pulse. result and result_err change only in a cycle where done is 1.
- R10: A private weight equal to the remainder is taken, so that bit is set and the remainder becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 20 | Register write data |
| start | input | 1 | Operation launch pulse |
| op_decrypt | input | 1 | 1 selects decrypt, 0 selects encrypt |
| blk_in | input | 8 | Plaintext block for encrypt |
| ct_in | input | 20 | Ciphertext for decrypt |
| busy | output | 1 | Decrypt in progress |
| done | output | 1 | Result valid pulse |
| result | output | 20 | Ciphertext, or recovered block in the low 8 bits |
| result_err | output | 1 | Nonzero remainder after the decrypt walk |
| config_error | output | 1 | Stored key violates the key rules |

## Verification
Two pairs of actions can fall in the same cycle. The first pair is a register write and a start. The bench drives a write to public weight 0 in the very cycle it launches an encrypt of block 0x01, then encrypts again. Both results must equal the old weight. The second pair is a register write or a second start that arrives while a decrypt is running. The bench injects both mid-run and judges that no early done appears, that the result matches the model decryption under the unchanged key, and that a repeat decrypt gives the same value.

// File: rtl/knap_pkg.sv
package knap_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_DEC  = 1'b1
   } eng_state_e;

   function automatic int unsigned cfg_addr_bits(input int unsigned n_wt);
      return $clog2(2 * n_wt + 3);
   endfunction

endpackage

// File: rtl/knap_key_bank.sv
module knap_key_bank #(
   parameter int N_WT      = 8,
   parameter int WT_W      = 16,
   parameter int MOD_W     = 20,
   parameter int ADDR_W    = 5,
   parameter bit CHECK_KEY = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [MOD_W-1:0]           wr_data,
   output logic [N_WT-1:0][WT_W-1:0]  pub_w,
   output logic [N_WT-1:0][WT_W-1:0]  prv_w,
   output logic [MOD_W-1:0]           mod_p,
   output logic [MOD_W-1:0]           inv_m,
   output logic                       key_bad
);

   localparam int A_MOD = 2 * N_WT;
   localparam int A_MUL = 2 * N_WT + 1;
   localparam int A_INV = 2 * N_WT + 2;

   logic [N_WT-1:0][WT_W-1:0] pub_q, prv_q;
   logic [MOD_W-1:0]          mod_q, mul_q, inv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pub_q <= '0;
         prv_q <= '0;
         mod_q <= '0;
         mul_q <= '0;
         inv_q <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < N_WT; i++) begin
            if (wr_addr == ADDR_W'(i))        pub_q[i] <= wr_data[WT_W-1:0];
            if (wr_addr == ADDR_W'(N_WT + i)) prv_q[i] <= wr_data[WT_W-1:0];
         end
         if (wr_addr == ADDR_W'(A_MOD)) mod_q <= wr_data;
         if (wr_addr == ADDR_W'(A_MUL)) mul_q <= wr_data;
         if (wr_addr == ADDR_W'(A_INV)) inv_q <= wr_data;
      end
   end

   assign pub_w = pub_q;
   assign prv_w = prv_q;
   assign mod_p = mod_q;
   assign inv_m = inv_q;

   generate
      if (CHECK_KEY) begin : g_chk
         logic [MOD_W-1:0] pre_sum [N_WT+1];
         logic [N_WT-1:0]  grows;
         assign pre_sum[0] = '0;
         for (genvar i = 0; i < N_WT; i++) begin : g_step
            assign pre_sum[i+1] = pre_sum[i] + MOD_W'(prv_q[i]);
            assign grows[i]     = MOD_W'(prv_q[i]) > pre_sum[i];
         end
         assign key_bad = ~(&grows) | (mod_q <= pre_sum[N_WT]) |
                          (mul_q >= mod_q) | (inv_q >= mod_q);
      end else begin : g_nochk
         assign key_bad = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/knap_modmul.sv
module knap_modmul #(
   parameter int MOD_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [MOD_W-1:0] mcand,
   input  logic [MOD_W-1:0] coef,
   input  logic [MOD_W-1:0] modulus,
   output logic [MOD_W-1:0] prod,
   output logic             fin
);

   localparam int CW = $clog2(MOD_W + 1);

   logic [MOD_W-1:0] acc_q, sh_q, nxt;
   logic [CW-1:0]    cnt_q;
   logic             run_q, fin_q;
   logic [MOD_W:0]   dbl, dbl_r, add_s, mod_x;

   always_comb begin
      mod_x = {1'b0, modulus};
      dbl   = {acc_q, 1'b0};
      dbl_r = (dbl >= mod_x) ? dbl - mod_x : dbl;
      add_s = dbl_r + (sh_q[MOD_W-1] ? {1'b0, coef} : '0);
      nxt   = MOD_W'((add_s >= mod_x) ? add_s - mod_x : add_s);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         sh_q  <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= run_q && (cnt_q == CW'(1));
         if (go) begin
            acc_q <= '0;
            sh_q  <= mcand;
            cnt_q <= CW'(MOD_W);
            run_q <= 1'b1;
         end else if (run_q) begin
            acc_q <= nxt;
            sh_q  <= sh_q << 1;
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) run_q <= 1'b0;
         end
      end
   end

   assign prod = acc_q;
   assign fin  = fin_q;

endmodule

// File: rtl/knap_greedy.sv
module knap_greedy #(
   parameter int N_WT  = 8,
   parameter int WT_W  = 16,
   parameter int MOD_W = 20
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      go,
   input  logic [MOD_W-1:0]          s_in,
   input  logic [N_WT-1:0][WT_W-1:0] prv_w,
   output logic [N_WT-1:0]           bits,
   output logic [MOD_W-1:0]          rem,
   output logic                      fin
);

   localparam int KW = $clog2(N_WT);

   logic [KW-1:0]    k_q;
   logic [MOD_W-1:0] s_q, wk;
   logic [N_WT-1:0]  bits_q;
   logic             run_q, fin_q, take;

   assign wk   = MOD_W'(prv_w[k_q]);
   assign take = (wk <= s_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_q    <= '0;
         s_q    <= '0;
         bits_q <= '0;
         run_q  <= 1'b0;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= run_q && (k_q == '0);
         if (go) begin
            s_q    <= s_in;
            k_q    <= KW'(N_WT - 1);
            bits_q <= '0;
            run_q  <= 1'b1;
         end else if (run_q) begin
            if (take) begin
               s_q         <= s_q - wk;
               bits_q[k_q] <= 1'b1;
            end
            if (k_q == '0) run_q <= 1'b0;
            else           k_q   <= k_q - KW'(1);
         end
      end
   end

   assign bits = bits_q;
   assign rem  = s_q;
   assign fin  = fin_q;

endmodule

// File: rtl/knap_engine.sv
module knap_engine #(
   parameter int N_WT      = 8,
   parameter int WT_W      = 16,
   parameter int MOD_W     = 20,
   parameter int ADDR_W    = 5,
   parameter bit CHECK_KEY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [MOD_W-1:0]  cfg_wdata,
   input  logic              start,
   input  logic              op_decrypt,
   input  logic [N_WT-1:0]   blk_in,
   input  logic [MOD_W-1:0]  ct_in,
   output logic              busy,
   output logic              done,
   output logic [MOD_W-1:0]  result,
   output logic              result_err,
   output logic              config_error
);
   import knap_pkg::*;

   generate
      if (N_WT < 2) begin : g_bad_n
         $error("knap_engine: N_WT must be at least 2");
      end
      if (WT_W + $clog2(N_WT) > MOD_W) begin : g_bad_w
         $error("knap_engine: MOD_W too narrow for a full weight sum");
      end
      if (ADDR_W < int'(cfg_addr_bits(N_WT))) begin : g_bad_a
         $error("knap_engine: ADDR_W too narrow for the register map");
      end
   endgenerate

   eng_state_e st_q;
   logic accept, wr_ok;
   logic [N_WT-1:0][WT_W-1:0] pub_w, prv_w;
   logic [MOD_W-1:0] mod_p, inv_m, mm_prod, g_rem, enc_sum;
   logic [N_WT-1:0]  g_bits;
   logic mm_fin, g_fin;
   logic [MOD_W-1:0] res_q;
   logic err_q, done_q;

   assign accept = start && (st_q == ST_IDLE);
   assign wr_ok  = cfg_we && (st_q == ST_IDLE) && !start;

   knap_key_bank #(
      .N_WT(N_WT), .WT_W(WT_W), .MOD_W(MOD_W),
      .ADDR_W(ADDR_W), .CHECK_KEY(CHECK_KEY)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_addr(cfg_addr),
      .wr_data(cfg_wdata), .pub_w(pub_w), .prv_w(prv_w),
      .mod_p(mod_p), .inv_m(inv_m), .key_bad(config_error)
   );

   knap_modmul #(.MOD_W(MOD_W)) u_mul (
      .clk(clk), .rst_n(rst_n), .go(accept && op_decrypt),
      .mcand(ct_in), .coef(inv_m), .modulus(mod_p),
      .prod(mm_prod), .fin(mm_fin)
   );

   knap_greedy #(.N_WT(N_WT), .WT_W(WT_W), .MOD_W(MOD_W)) u_grd (
      .clk(clk), .rst_n(rst_n), .go(mm_fin), .s_in(mm_prod),
      .prv_w(prv_w), .bits(g_bits), .rem(g_rem), .fin(g_fin)
   );

   always_comb begin
      enc_sum = '0;
      for (int i = 0; i < N_WT; i++)
         if (blk_in[i]) enc_sum = enc_sum + MOD_W'(pub_w[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         res_q  <= '0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept && !op_decrypt) begin
            res_q  <= enc_sum;
            err_q  <= 1'b0;
            done_q <= 1'b1;
         end else if (accept) begin
            st_q <= ST_DEC;
         end else if (st_q == ST_DEC && g_fin) begin
            res_q  <= MOD_W'(g_bits);
            err_q  <= (g_rem != '0);
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
         end
      end
   end

   assign busy       = (st_q == ST_DEC);
   assign done       = done_q;
   assign result     = res_q;
   assign result_err = err_q;

endmodule

// File: rtl/knap_engine_chk.sv
module knap_engine_chk #(
   parameter int MOD_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             op_decrypt,
   input logic             busy,
   input logic             done,
   input logic [MOD_W-1:0] result,
   input logic             result_err
);

   AST_ENC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !op_decrypt) |=> (done && !result_err)); // R3
   AST_DEC_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op_decrypt) |=> (busy && !done)); // R6
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(result_err))); // R9
   AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !op_decrypt) |=> !done || !busy); // R6

endmodule

bind knap_engine knap_engine_chk #(.MOD_W(MOD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op_decrypt(op_decrypt),
   .busy(busy), .done(done), .result(result), .result_err(result_err)
);

// File: tb/knap_engine_tb_top.sv
module knap_engine_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [4:0] cfg_addr = '0;
   logic [19:0] cfg_wdata = '0;
   logic start = 1'b0;
   logic op_decrypt = 1'b0;
   logic [7:0] blk_in = '0;
   logic [19:0] ct_in = '0;
   logic busy, done, result_err, config_error;
   logic [19:0] result;

   int n_chk = 0;
   int n_bad = 0;
   longint prv [8];
   longint pub [8];
   longint p_m, m_m, inv_m;
   longint res_v, err_v;
   int lat_v;

   always #5 clk = ~clk;

   knap_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .start(start), .op_decrypt(op_decrypt),
      .blk_in(blk_in), .ct_in(ct_in), .busy(busy), .done(done),
      .result(result), .result_err(result_err), .config_error(config_error)
   );

   function automatic longint gcd(input longint a, input longint b);
      longint x = a, y = b, t;
      while (y != 0) begin t = x % y; x = y; y = t; end
      return x;
   endfunction

   function automatic longint modinv(input longint a, input longint m);
      longint t = 0, nt = 1, r = m, nr = a, q, tmp;
      while (nr != 0) begin
         q = r / nr;
         tmp = t - q * nt; t = nt; nt = tmp;
         tmp = r - q * nr; r = nr; nr = tmp;
      end
      if (t < 0) t = t + m;
      return t;
   endfunction

   function automatic longint ref_enc(input logic [7:0] b);
      longint s = 0;
      for (int i = 0; i < 8; i++) if (b[i]) s = s + pub[i];
      return s;
   endfunction

   function automatic longint ref_dec(input longint ct, output longint err);
      longint s = (ct * inv_m) % p_m;
      longint bits = 0;
      for (int k = 7; k >= 0; k--)
         if (prv[k] <= s) begin s = s - prv[k]; bits = bits | (longint'(1) << k); end
      err = (s != 0) ? 1 : 0;
      return bits;
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input longint data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = 20'(data);
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_key();
      for (int i = 0; i < 8; i++) wr(i, pub[i]);
      for (int i = 0; i < 8; i++) wr(8 + i, prv[i]);
      wr(16, p_m); wr(17, m_m); wr(18, inv_m);
   endtask

   task automatic finish_key();
      inv_m = modinv(m_m, p_m);
      for (int i = 0; i < 8; i++) pub[i] = (m_m * prv[i]) % p_m;
   endtask

   task automatic gen_key();
      longint s = 0;
      for (int i = 0; i < 8; i++) begin
         prv[i] = s + 1 + longint'($urandom % 40);
         s = s + prv[i];
      end
      p_m = s + 1 + longint'($urandom % 2000);
      do m_m = 2 + longint'($urandom % 32'(p_m - 3)); while (gcd(m_m, p_m) != 1);
      finish_key();
   endtask

   task automatic run_op(input bit dec, input logic [7:0] blk, input logic [19:0] ct);
      @(negedge clk);
      start = 1'b1; op_decrypt = dec; blk_in = blk; ct_in = ct;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat_v = 0;
      while (!done && lat_v < 100) begin
         @(posedge clk); @(negedge clk); lat_v++;
      end
      res_v = result; err_v = result_err;
   endtask

   task automatic round_trips(input int cnt);
      longint e, d;
      logic [7:0] b;
      for (int t = 0; t < cnt; t++) begin
         b = 8'($urandom);
         run_op(1'b0, b, '0);
         chk("R3 encrypt sum", res_v, ref_enc(b));
         chk("R3 encrypt err", err_v, 0);
         chk("R3 encrypt latency", lat_v, 0);
         run_op(1'b1, '0, 20'(res_v));
         d = ref_dec(ref_enc(b), e);
         chk("R4 decrypt block", res_v, d);
         chk("R5 decrypt err", err_v, e);
         chk("R4 decrypt latency", lat_v, 30);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      longint e, d, old0, s3, ct;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 done", done, 0);
      chk("R1 busy", busy, 0);
      chk("R1 result", result, 0);
      chk("R1 result_err", result_err, 0);
      chk("R1 config_error", config_error, 1);
      rst_n = 1'b1;

      // directed key: powers of two, large modulus
      for (int i = 0; i < 8; i++) prv[i] = longint'(1) << i;
      p_m = 65521; m_m = 40000;
      finish_key();
      load_key();
      chk("R2 R8 valid key accepted", config_error, 0);
      run_op(1'b0, 8'h01, '0);
      chk("R2 weight 0 stored", res_v, pub[0]);
      run_op(1'b0, 8'h00, '0);
      chk("R3 empty block", res_v, 0);
      run_op(1'b0, 8'hFF, '0);
      chk("R3 full block", res_v, ref_enc(8'hFF));
      run_op(1'b1, '0, 20'(pub[0]));
      chk("R10 equal weight taken", res_v, 1);
      chk("R10 remainder zero", err_v, 0);
      run_op(1'b1, '0, 20'(pub[7]));
      chk("R10 top weight equal", res_v, 128);
      round_trips(10);

      // config checks
      gen_key();
      load_key();
      chk("R8 random key valid", config_error, 0);
      s3 = prv[0] + prv[1] + prv[2];
      wr(11, s3);
      chk("R8 weight equal to prefix sum", config_error, 1);
      wr(11, prv[3]);
      chk("R8 weight restored", config_error, 0);
      wr(16, prv[0] + prv[1] + prv[2] + prv[3] + prv[4] + prv[5] + prv[6] + prv[7]);
      chk("R8 modulus equal to total", config_error, 1);
      wr(16, p_m);
      wr(17, p_m);
      chk("R8 multiplier at modulus", config_error, 1);
      wr(17, m_m);
      wr(18, p_m);
      chk("R8 inverse at modulus", config_error, 1);
      wr(18, inv_m);
      chk("R8 key restored", config_error, 0);

      // write in the same cycle as start
      old0 = pub[0];
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 5'd0; cfg_wdata = 20'(old0 ^ 1);
      start = 1'b1; op_decrypt = 1'b0; blk_in = 8'h01;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0; start = 1'b0;
      chk("R7 start+write uses old weight", result, old0);
      chk("R9 done pulse high", done, 1);
      @(negedge clk);
      chk("R9 done pulse low", done, 0);
      run_op(1'b0, 8'h01, '0);
      chk("R7 start+write discarded", res_v, old0);

      // start and write while busy
      ct = ref_enc(8'hA5);
      @(negedge clk);
      start = 1'b1; op_decrypt = 1'b1; ct_in = 20'(ct);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R6 busy after decrypt start", busy, 1);
      repeat (4) @(negedge clk);
      start = 1'b1; op_decrypt = 1'b0; blk_in = 8'hFF;
      @(negedge clk);
      start = 1'b0;
      cfg_we = 1'b1; cfg_addr = 5'd18; cfg_wdata = '0;
      @(negedge clk);
      cfg_we = 1'b0;
      lat_v = 6;
      begin
         int early = 0;
         while (!done && lat_v < 100) begin
            @(posedge clk); @(negedge clk); lat_v++;
         end
         if (lat_v != 30) early = 1;
         chk("R6 start while busy ignored", early, 0);
      end
      d = ref_dec(ct, e);
      chk("R6 busy result", result, d);
      run_op(1'b1, '0, 20'(ct));
      chk("R7 write while busy discarded", res_v, d);

      // random keys and random ciphertexts
      for (int kk = 0; kk < 5; kk++) begin
         gen_key();
         load_key();
         chk("R8 generated key valid", config_error, 0);
         round_trips(12);
         for (int r = 0; r < 8; r++) begin
            ct = longint'($urandom & 32'hFFFFF);
            run_op(1'b1, '0, 20'(ct));
            d = ref_dec(ct, e);
            chk("R4 random ciphertext", res_v, d);
            chk("R5 random ciphertext err", err_v, e);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule